// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

The block is a reconfigurable AND/OR plane. Twelve dedicated inputs and ten feedback inputs are each split into a true line and a complement line, which gives 44 array lines. Every product term is an AND over the lines whose crosspoint cell is closed. Groups of sum terms are ORed into ten sum outputs. Separate rows supply per-output enable terms and single terms for preset, clear and clock. Those special terms are produced here and are not consumed by the block.

The crosspoint pattern is held in an internal bit store. A command port changes it. A bulk erase sweeps every row and opens every cell; while it runs the port is busy. Write and read commands each address one cell by row and column, and each takes one cycle. The array evaluates combinationally from the stored bits. A `logic_valid` flag marks the cycles in which the outputs may be trusted, which excludes the cycles around a configuration change. An erased row evaluates TRUE, so software must close both polarities of one signal on every row it leaves unused.

Top module: `pla_array`

## Requirements
- R1: While `rst` is high, `logic_valid` is low. In the first cycle after reset, `logic_valid` and `cmd_ready` are high and every cell is open.
- R2: Array column 2k carries signal k true and column 2k+1 carries it inverted. Signals 0..11 are `ded_in[0..11]` and signals 12..21 are `fb_in[0..9]`.
- R3: A product term is the AND of the lines at its closed cells. A row with no closed cell is TRUE.
- R4: A row with both columns of one signal closed is FALSE for every input.
- R5: Sum output o ORs a contiguous group of rows. Group sizes for outputs 0..9 are 8,10,12,14,16,16,14,12,10,8, and output 0 starts at row 0.
- R6: Rows 120..129 drive `oe_term[0..9]`. Row 130 drives `preset_term`, row 131 drives `clear_term` and row 132 drives `clock_term`.
- R7: A write (`cmd_op`=1) sets the cell at (`cmd_row`,`cmd_col`) to `cmd_data`. A read (`cmd_op`=2) returns that cell on `rd_bit` from the next cycle on, and returns 0 for an address outside the array.
- R8: An erase (`cmd_op`=0) opens every cell. `cmd_ready` is low for the 133 cycles of the sweep, and commands offered in that time are ignored.
- R9: `logic_valid` is low in the cycle after any accepted command. It is high again one cycle after the command completes.
- R10: A write to a row above 132 or a column above 43 is ignored, and so is `cmd_op`=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ded_in | input | 12 | Dedicated inputs |
| fb_in | input | 10 | Feedback inputs |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | 0 erase, 1 write, 2 read, 3 none |
| cmd_row | input | 8 | Product-term row address |
| cmd_col | input | 6 | Array column address |
| cmd_data | input | 1 | Write value (1 = closed) |
| cmd_ready | output | 1 | Command port idle |
| rd_bit | output | 1 | Registered read result |
| sum_out | output | 10 | OR of each output's sum terms |
| oe_term | output | 10 | Per-output enable terms |
| preset_term | output | 1 | Global preset term |
| clear_term | output | 1 | Global clear term |
| clock_term | output | 1 | Clock term |
| logic_valid | output | 1 | Outputs reflect a settled pattern |

## Verification
The erase sweep and an incoming write can fall in the same cycle. The bench provokes this by offering a write to the clear row while the sweep is still running. It then confirms that the clear term stays TRUE and that a read of that cell returns 0, which shows the sweep won and the write was dropped. The second collision is between an input change and a configuration change. The table walk only samples while `logic_valid` is high, and a bound property checks that with the flag held and the inputs steady the outputs do not move.

// File: rtl/pla_pkg.sv
package pla_pkg;
    localparam int N_DED   = 12;
    localparam int N_FB    = 10;
    localparam int N_SIG   = N_DED + N_FB;
    localparam int N_LINES = 2 * N_SIG;
    localparam int N_OUT   = N_FB;
    localparam int ROW_W   = 8;
    localparam int COL_W   = 6;

    function automatic int term_cnt(input int o);
        return (o < N_OUT / 2) ? 8 + 2 * o : 8 + 2 * (N_OUT - 1 - o);
    endfunction

    function automatic int term_base(input int o);
        int acc = 0;
        for (int i = 0; i < o; i++) acc += term_cnt(i);
        return acc;
    endfunction

    localparam int N_SUM      = term_base(N_OUT);
    localparam int OE_BASE    = N_SUM;
    localparam int PRESET_ROW = OE_BASE + N_OUT;
    localparam int CLEAR_ROW  = PRESET_ROW + 1;
    localparam int CLOCK_ROW  = PRESET_ROW + 2;
    localparam int N_ROWS     = PRESET_ROW + 3;

    typedef enum logic [1:0] {
        OP_ERASE = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_NONE  = 2'd3
    } cfg_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } cfg_state_e;

    typedef struct packed {
        cfg_op_e           op;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              data;
    } cfg_cmd_t;
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store
    import pla_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cmd_valid,
    input  cfg_cmd_t                       cmd,
    output logic                           cmd_ready,
    output logic                           rd_bit,
    output logic                           logic_valid,
    output logic [N_ROWS-1:0][N_LINES-1:0] cells
);
    cfg_state_e       state_q;
    logic [ROW_W-1:0] sweep_q;
    logic             accept;
    logic             addr_ok;

    assign cmd_ready = (state_q == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready && (cmd.op != OP_NONE);
    assign addr_ok   = (int'(cmd.row) < N_ROWS) && (int'(cmd.col) < N_LINES);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            sweep_q     <= '0;
            cells       <= '0;
            rd_bit      <= 1'b0;
            logic_valid <= 1'b0;
        end else begin
            logic_valid <= (state_q == ST_IDLE) && !accept;
            if (state_q == ST_SWEEP) begin
                cells[sweep_q] <= '0;
                if (int'(sweep_q) == N_ROWS - 1) begin
                    state_q <= ST_IDLE;
                end else begin
                    sweep_q <= sweep_q + 1'b1;
                end
            end else if (accept) begin
                unique case (cmd.op)
                    OP_ERASE: begin
                        state_q <= ST_SWEEP;
                        sweep_q <= '0;
                    end
                    OP_WRITE: if (addr_ok) cells[cmd.row][cmd.col] <= cmd.data;
                    OP_READ:  rd_bit <= addr_ok ? cells[cmd.row][cmd.col] : 1'b0;
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pla_term_eval.sv
module pla_term_eval
    import pla_pkg::*;
(
    input  logic [N_DED-1:0]               ded_in,
    input  logic [N_FB-1:0]                fb_in,
    input  logic [N_ROWS-1:0][N_LINES-1:0] cells,
    output logic [N_ROWS-1:0]              terms
);
    logic [N_SIG-1:0]   sig;
    logic [N_LINES-1:0] lines;

    assign sig = {fb_in, ded_in};

    for (genvar k = 0; k < N_SIG; k++) begin : g_line
        assign lines[2*k]   = sig[k];
        assign lines[2*k+1] = ~sig[k];
    end

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        assign terms[r] = &(~cells[r] | lines);
    end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
    import pla_pkg::*;
(
    input  logic [N_ROWS-1:0] terms,
    output logic [N_OUT-1:0]  sum_out,
    output logic [N_OUT-1:0]  oe_term,
    output logic              preset_term,
    output logic              clear_term,
    output logic              clock_term
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        localparam int BASE = term_base(o);
        localparam int CNT  = term_cnt(o);
        assign sum_out[o] = |terms[BASE +: CNT];
        assign oe_term[o] = terms[OE_BASE + o];
    end

    assign preset_term = terms[PRESET_ROW];
    assign clear_term  = terms[CLEAR_ROW];
    assign clock_term  = terms[CLOCK_ROW];
endmodule

// File: rtl/pla_array.sv
module pla_array
    import pla_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_DED-1:0] ded_in,
    input  logic [N_FB-1:0]  fb_in,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [ROW_W-1:0] cmd_row,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_data,
    output logic             cmd_ready,
    output logic             rd_bit,
    output logic [N_OUT-1:0] sum_out,
    output logic [N_OUT-1:0] oe_term,
    output logic             preset_term,
    output logic             clear_term,
    output logic             clock_term,
    output logic             logic_valid
);
    cfg_cmd_t                       cmd;
    logic [N_ROWS-1:0][N_LINES-1:0] cells;
    logic [N_ROWS-1:0]              terms;

    assign cmd = '{op: cfg_op_e'(cmd_op), row: cmd_row, col: cmd_col, data: cmd_data};

    pla_cfg_store u_store (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd),
        .cmd_ready(cmd_ready), .rd_bit(rd_bit), .logic_valid(logic_valid),
        .cells(cells)
    );

    pla_term_eval u_eval (
        .ded_in(ded_in), .fb_in(fb_in), .cells(cells), .terms(terms)
    );

    pla_or_plane u_or (
        .terms(terms), .sum_out(sum_out), .oe_term(oe_term),
        .preset_term(preset_term), .clear_term(clear_term), .clock_term(clock_term)
    );
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk
    import pla_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [N_DED-1:0] ded_in,
    input logic [N_FB-1:0]  fb_in,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic             cmd_ready,
    input logic             rd_bit,
    input logic [N_OUT-1:0] sum_out,
    input logic [N_OUT-1:0] oe_term,
    input logic             preset_term,
    input logic             clear_term,
    input logic             clock_term,
    input logic             logic_valid
);
    logic take;
    logic last_erase;
    assign take = cmd_valid && cmd_ready && (cmd_op != 2'd3);

    always_ff @(posedge clk) begin
        if (rst) last_erase <= 1'b0;
        else if (take) last_erase <= (cmd_op == 2'd0);
    end

    // R9: an accepted command makes the outputs untrusted in the next cycle
    assert_cmd_drops_valid_R9: assert property (@(posedge clk) disable iff (rst)
        take |=> !logic_valid);

    // R8: a running sweep never reports valid outputs
    assert_busy_not_valid_R8: assert property (@(posedge clk) disable iff (rst)
        !cmd_ready |-> !logic_valid);

    // R3: once an erase finishes, every open row evaluates TRUE
    assert_erased_all_true_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(logic_valid) && last_erase) |->
            (&sum_out && &oe_term && preset_term && clear_term && clock_term));

    // R5: with the pattern and inputs held, the outputs hold as well
    assert_outputs_steady_R5: assert property (@(posedge clk) disable iff (rst)
        (logic_valid && $past(logic_valid) && $stable(ded_in) && $stable(fb_in)) |->
            ($stable(sum_out) && $stable(oe_term) && $stable(clear_term)));

    // R7: the read result changes only after an accepted read
    assert_rd_only_on_read_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(take && cmd_op == 2'd2) |-> $stable(rd_bit));
endmodule

bind pla_array pla_array_chk u_chk (
    .clk(clk), .rst(rst), .ded_in(ded_in), .fb_in(fb_in),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
    .rd_bit(rd_bit), .sum_out(sum_out), .oe_term(oe_term),
    .preset_term(preset_term), .clear_term(clear_term),
    .clock_term(clock_term), .logic_valid(logic_valid)
);

// File: tb/pla_array_test.sv
module pla_array_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] ded_in;
    logic [9:0]  fb_in;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [7:0]  cmd_row;
    logic [5:0]  cmd_col;
    logic        cmd_data;
    logic        cmd_ready, rd_bit, preset_term, clear_term, clock_term, logic_valid;
    logic [9:0]  sum_out, oe_term;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pla_array uut (
        .clk(clk), .rst(rst), .ded_in(ded_in), .fb_in(fb_in),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .rd_bit(rd_bit), .sum_out(sum_out), .oe_term(oe_term),
        .preset_term(preset_term), .clear_term(clear_term),
        .clock_term(clock_term), .logic_valid(logic_valid)
    );

    // {d2,d1,d0,fb0, exp_sum1, exp_sum0, exp_oe0, exp_preset}
    localparam logic [5:0][7:0] VEC = {
        8'b1000_0010, 8'b0001_1001, 8'b1100_0010,
        8'b1011_1110, 8'b0111_1001, 8'b0010_0101
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input int row, input int col, input logic d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        cmd_row = 8'(row); cmd_col = 6'(col); cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_valid();
        while (!logic_valid) @(negedge clk);
    endtask

    task automatic walk_table(input string tag);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            ded_in = {9'h1A5, VEC[i][7:5]};
            fb_in  = {9'h0C3, VEC[i][4]};
            #1;
            check(sum_out[1:0] == VEC[i][3:2], tag, sum_out[1:0], VEC[i][3:2]);
            check(oe_term[0] == VEC[i][1] && preset_term == VEC[i][0], tag,
                  {oe_term[0], preset_term}, VEC[i][1:0]);
            check(sum_out[9:2] == 8'hFF && clock_term && !clear_term, "R4", // R4 clear row forced FALSE
                  {sum_out[9:2], clock_term, clear_term}, 10'h3FE);
        end
    endtask

    task automatic program_pattern();
        issue(2'd1, 0, 0, 1'b1);
        issue(2'd1, 0, 3, 1'b1);
        for (int r = 1; r < 8; r++) begin
            issue(2'd1, r, 0, 1'b1); issue(2'd1, r, 1, 1'b1);
        end
        issue(2'd1, 8, 24, 1'b1);
        for (int r = 9; r < 18; r++) begin
            issue(2'd1, r, 24, 1'b1); issue(2'd1, r, 25, 1'b1);
        end
        issue(2'd1, 120, 4, 1'b1);
        issue(2'd1, 130, 5, 1'b1);
        issue(2'd1, 131, 6, 1'b1);
        issue(2'd1, 131, 7, 1'b1);
        wait_valid();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int busy_cnt;
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'd3; cmd_row = '0; cmd_col = '0;
        cmd_data = 1'b0; ded_in = '0; fb_in = '0;
        repeat (3) @(negedge clk);
        check(!logic_valid, "R1", logic_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(logic_valid && cmd_ready, "R1", {logic_valid, cmd_ready}, 3);
        check(&sum_out && &oe_term && preset_term && clear_term && clock_term, "R1 R3",
              {sum_out, oe_term}, 20'hFFFFF);

        program_pattern();
        walk_table("R2 R3 R5 R6");

        // R7: read back a closed and an open cell
        issue(2'd2, 8, 24, 1'b0);
        check(rd_bit == 1'b1, "R7", rd_bit, 1);
        check(!logic_valid, "R9", logic_valid, 0);
        @(negedge clk);
        check(logic_valid, "R9", logic_valid, 1);
        issue(2'd2, 8, 25, 1'b0);
        check(rd_bit == 1'b0, "R7", rd_bit, 0);

        // R10: writes out of range and no-op code leave the pattern intact
        issue(2'd1, 200, 0, 1'b1);
        issue(2'd1, 132, 50, 1'b1);
        issue(2'd3, 132, 0, 1'b1);
        wait_valid();
        walk_table("R10");
        issue(2'd2, 200, 0, 1'b0);
        check(rd_bit == 1'b0, "R7 R10", rd_bit, 0);

        // R7: reopen a cell, then close it again
        issue(2'd1, 0, 3, 1'b0);
        @(negedge clk);
        ded_in[2:0] = 3'b011; #1;
        check(sum_out[0] == 1'b1, "R7", sum_out[0], 1);
        issue(2'd1, 0, 3, 1'b1);
        @(negedge clk); #1;
        check(sum_out[0] == 1'b0, "R7", sum_out[0], 0);

        // R8: erase sweep with a colliding write
        issue(2'd0, 0, 0, 1'b0);
        check(!cmd_ready, "R8", cmd_ready, 0);
        issue(2'd1, 131, 1, 1'b1);
        busy_cnt = 2;
        while (!cmd_ready) begin @(negedge clk); busy_cnt++; end
        check(busy_cnt == 133, "R8", busy_cnt, 133);
        check(!logic_valid, "R9", logic_valid, 0);
        @(negedge clk);
        check(logic_valid, "R9", logic_valid, 1);
        ded_in = 12'hFFF; fb_in = '0; #1;
        check(clear_term && &sum_out && preset_term, "R8", {clear_term, sum_out}, 11'h7FF);
        issue(2'd2, 131, 1, 1'b0);
        check(rd_bit == 1'b0, "R8", rd_bit, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule